// File: doc/BRIEF.md
# Hardware Semaphore Bank

A bank of single-bit hardware semaphores behind a simple synchronous register bus. Several processor cores share it. Each semaphore takes one 32-bit word of the address space. A core claims a semaphore by reading that word. The read is an indivisible test-and-set: it returns 1 when the semaphore was free, and the semaphore is then held. It returns 0 when another party already holds it. The holder frees the semaphore by writing zero to the same word.

The bus gives one access per cycle. The read path therefore serializes competing claims without any extra arbitration: of two reads aimed at a free semaphore, only the first one wins. Every access is answered one clock later with a ready pulse, and read data is registered alongside that pulse.

Top module: `hsem_bank`

## Requirements
- R1: After reset all semaphores are free, `bus_ready` is 0 and `bus_rdata` is 0.
- R2: A read of a free semaphore returns 1 in bit 0 of `bus_rdata`, with bits 31..1 zero, and leaves that semaphore held.
- R3: A read of a held semaphore returns 0 and leaves it held. Two consecutive reads of a free semaphore therefore return 1 and then 0.
- R4: A write of value 0 to a semaphore's word frees it, so the next read of that word returns 1.
- R5: A write of any nonzero value has no effect on the semaphore state.
- R6: Semaphore n, for n in 0..29, sits at byte address 0x404 + 4*n. Any other address, including misaligned ones and 0x47C, reads as 0. An access to such an address changes no semaphore.
- R7: An access changes at most the one semaphore it addresses.
- R8: Every cycle with `bus_rd` or `bus_wr` high is followed by exactly one cycle with `bus_ready` high, and the read result appears in that same cycle. A cycle with neither strobe is followed by `bus_ready` low and `bus_rdata` 0. A write answers with `bus_rdata` 0.
- R9: When `bus_rd` and `bus_wr` are both high, only the read is performed and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_rd | input | 1 | Read strobe (claim attempt) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; zero frees the semaphore |
| bus_rdata | output | 32 | Registered read result; bit 0 is the grant |
| bus_ready | output | 1 | Access completed, one cycle after the strobe |

## Verification
The bench builds the block with its default parameters: 30 semaphores, a 12-bit address and a base offset of 0x404. With these values it can reach the lowest and highest semaphore words and the first word past the bank, 0x47C. It also covers the word just below the base and misaligned addresses inside the range. Random traffic spread over slightly more addresses than the bank decodes mixes claims, releases, nonzero writes and misses. Every read is compared against a bench model, so any disturbance of a neighbouring semaphore shows up on a later read.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } hsem_op_e;

    // A read wins over a simultaneous write.
    function automatic hsem_op_e classify(input logic rd, input logic wr);
        if (rd)      return OP_READ;
        else if (wr) return OP_WRITE;
        else         return OP_IDLE;
    endfunction

endpackage

// File: rtl/hsem_decode.sv
module hsem_decode #(
    parameter int              NUM_LOCKS = 30,
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_OFF  = 12'h404,
    localparam int             IDX_W     = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN_W = ADDR_W + 1;

    logic [SPAN_W-1:0] offset;
    logic [SPAN_W-1:0] word;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, BASE_OFF};
        word   = offset >> 2;
        hit    = (addr >= BASE_OFF) && (offset[1:0] == 2'b00)
                 && (word < SPAN_W'(NUM_LOCKS));
        idx    = word[IDX_W-1:0];
    end

endmodule

// File: rtl/hsem_flags.sv
module hsem_flags
    import hsem_pkg::*;
#(
    parameter int NUM_LOCKS = 30,
    localparam int IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hsem_op_e         op,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic             wzero,
    output logic             grant
);
    typedef struct packed {
        logic [NUM_LOCKS-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        grant = 1'b0;
        if (hit) begin
            if (op == OP_READ && !st_q.flags[idx]) begin
                st_d.flags[idx] = 1'b1;
                grant           = 1'b1;
            end else if (op == OP_WRITE && wzero) begin
                st_d.flags[idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_READ_LEAVES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ && hit) |=> st_q.flags[$past(idx)]);               // R3
    AST_ZERO_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && hit && wzero) |=> !st_q.flags[$past(idx)]);    // R4
    AST_NONZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE && !wzero) |=> $stable(st_q.flags));              // R5
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q.flags));                                    // R6
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.flags ^ $past(st_q.flags)) <= 1);                 // R7

endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int              NUM_LOCKS = 30,
    parameter int              ADDR_W    = 12,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_OFF  = 12'h404
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready
);
    localparam int IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } rsp_st_t;

    rsp_st_t          rsp_d, rsp_q;
    hsem_op_e         op;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic             grant;

    assign op = classify(bus_rd, bus_wr);

    hsem_decode #(
        .NUM_LOCKS (NUM_LOCKS),
        .ADDR_W    (ADDR_W),
        .BASE_OFF  (BASE_OFF)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    hsem_flags #(
        .NUM_LOCKS (NUM_LOCKS)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .hit   (hit),
        .idx   (idx),
        .wzero (bus_wdata == '0),
        .grant (grant)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.ready = (op != OP_IDLE);
        rsp_d.rdata = {{(DATA_W-1){1'b0}}, grant};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_ready = rsp_q.ready;
    assign bus_rdata = rsp_q.rdata;

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_IDLE) |=> bus_ready);                                   // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> (!bus_ready && bus_rdata == '0));             // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:1] == '0);                                     // R2
    AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd) |=> (bus_rdata == '0));                       // R8

endmodule

// File: tb/hsem_bank_bench.sv
module hsem_bank_bench;
    localparam int N    = 30;
    localparam int BASE = 'h404;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    bit model [N];
    int checks = 0, errs = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hsem_bank u_hsem_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    function automatic bit decode(input int a, output int n);
        n = (a - BASE) / 4;
        return (a >= BASE) && (((a - BASE) % 4) == 0) && (n < N);
    endfunction

    function automatic logic [11:0] addr_of(input int n);
        return 12'(BASE + 4 * n);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input bit rd, input bit wr, input logic [11:0] a,
                          input logic [31:0] d, input string req);
        int n;
        bit h;
        logic [31:0] exp_r;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        h = decode(int'(a), n);
        exp_r = '0;
        if (rd) begin
            if (h) begin
                exp_r = {31'd0, !model[n]};
                model[n] = 1'b1;
            end
        end else if (wr && h && d == 0) begin
            model[n] = 1'b0;
        end
        @(posedge clk); #2;
        check({req, " ready"}, {31'd0, bus_ready}, {31'd0, rd | wr});
        check({req, " rdata"}, bus_rdata, exp_r);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        @(posedge clk); #2;
        check("R8 idle ready", {31'd0, bus_ready}, 32'd0);
        check("R8 idle rdata", bus_rdata, 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset ready", {31'd0, bus_ready}, 32'd0);
        check("R1 reset rdata", bus_rdata, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        idle_cycle();

        // R1 R2 R6: every word of a fresh bank grants once
        for (int i = 0; i < N; i++) access(1, 0, addr_of(i), 0, "R1 R2 R6 first claim");
        access(1, 0, addr_of(0), 0, "R3 held read");
        access(0, 1, addr_of(5), 0, "R4 release");
        access(0, 1, addr_of(6), 32'h1, "R5 nonzero write");
        access(1, 0, addr_of(6), 0, "R5 still held");
        access(1, 0, addr_of(5), 0, "R4 reclaim");
        access(0, 1, addr_of(7), 0, "R4 release");
        access(1, 0, addr_of(7), 0, "R3 back-to-back first");
        access(1, 0, addr_of(7), 0, "R3 back-to-back second");
        idle_cycle();

        // R6 misses around the bank
        access(0, 1, 12'h400, 0, "R6 write below base");
        access(0, 1, 12'h47C, 0, "R6 write past end");
        access(0, 1, 12'h405, 0, "R6 misaligned write");
        access(1, 0, 12'h47C, 0, "R6 read past end");
        access(1, 0, 12'h400, 0, "R6 read below base");
        access(1, 0, addr_of(0), 0, "R6 R7 lock0 unaffected");
        access(0, 1, addr_of(29), 0, "R4 top release");
        access(1, 0, addr_of(28), 0, "R7 neighbour held");
        access(1, 0, addr_of(29), 0, "R4 R6 top reclaim");

        // R9 read wins over write
        access(0, 1, addr_of(3), 0, "R9 prep release");
        access(1, 1, addr_of(3), 0, "R9 combined grants");
        access(1, 0, addr_of(3), 0, "R9 write discarded");
        idle_cycle();

        // random mix, R7 disturbance shows on later reads
        for (int k = 0; k < 3000; k++) begin
            int sel = int'($urandom_range(0, 33)) - 1;
            int kind = int'($urandom_range(0, 9));
            logic [11:0] a = (sel < 0) ? 12'h400 : 12'(BASE + 4 * sel);
            if ($urandom_range(0, 15) == 0) a = a + 12'd2;
            if (kind < 5)       access(1, 0, a, 0, "R2 R3 R7 random read");
            else if (kind < 8)  access(0, 1, a, 0, "R4 R7 random release");
            else if (kind < 9)  access(0, 1, a, $urandom | 32'h10, "R5 random nonzero");
            else                idle_cycle();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end

endmodule